// File: doc/BRIEF.md
# Dual 64-Byte FIFO Controller with Mirrored Threshold Flags

This block holds two byte-wide queues of 64 entries each. The receive queue is filled by a radio-side producer strobe and emptied by a host read strobe. The transmit queue is filled by a host write strobe and emptied by a radio-side consumer strobe. Each queue reports its byte count and carries two sticky error flags. A write to a full queue and a read from an empty queue are both refused, and each sets its flag. The host-side serial link and the radio datapath are not part of the block; plain one-cycle strobes take their place.

A single 4-bit threshold setting N drives both threshold flags, counted in opposite directions. The receive flag trips at 4·(N+1) bytes. The transmit flag trips at 61−4·N bytes. The two thresholds therefore always add up to 65, which leaves equal headroom against receive overflow and transmit underflow. During a host access, a 4-bit fill indication shows the count of the queue the access touches, capped at 15.

Each queue is run by a small occupancy state machine with three states:
- `OCC_EMPTY` moves to `OCC_PARTIAL` when a write is accepted.
- `OCC_PARTIAL` moves to `OCC_FULL` when a lone write lands at 63 bytes.
- `OCC_PARTIAL` moves to `OCC_EMPTY` when a lone read leaves 1 byte.
- `OCC_FULL` moves to `OCC_PARTIAL` when a read is accepted.
- A flush forces `OCC_EMPTY` from any state.

Top module: `paired_fifo_ctrl`

## Requirements
- R1: Reset empties both queues and clears all error flags. A flush of one queue sets that queue's count to 0 and clears that queue's two error flags, and leaves the other queue untouched. Any strobe on a queue in its flush cycle is ignored.
- R2: Bytes leave each queue in the order they were accepted, and a queue holds 64 bytes. The read data output always shows the oldest stored byte, and a read strobe removes it.
- R3: A write to a full queue (count 64) is refused: the count stays 64 and the stored bytes are unchanged. Such a write sets the queue's write error flag (`rx_overflow_err` for a radio write, `tx_overfill_err` for a host write). The flag holds until reset or flush.
- R4: A read from an empty queue is refused and the count stays 0. Such a read sets the queue's read error flag (`rx_underread_err` for a host read, `tx_underflow_err` for a radio read). The flag holds until reset or flush.
- R5: When a read and a write hit a queue in the same cycle and the count is between 1 and 63, both are accepted and the count is unchanged. With exactly one byte stored, the read returns that byte and the new byte becomes the oldest, so no byte is returned twice. At full, only the read is accepted and the write error flag is set. At empty, only the write is accepted and the read error flag is set.
- R6: `rx_thr_flag` is 1 exactly when `rx_count` ≥ 4·(N+1), where N is `thr_sel`.
- R7: `tx_thr_flag` is 1 exactly when `tx_count` ≥ 61−4·N, where N is `thr_sel`.
- R8: When `host_acc`=1, `fill_ind` equals min(count, 15). The count is taken from the receive queue when `host_acc_rd`=1 and from the transmit queue when `host_acc_rd`=0. When `host_acc`=0, `fill_ind` is 0.
- R9: Counts are registered. An accepted strobe sampled at a rising clock edge is reflected in `rx_count`/`tx_count` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_sel | input | 4 | Shared threshold setting N |
| rx_flush | input | 1 | Synchronous clear of the receive queue |
| tx_flush | input | 1 | Synchronous clear of the transmit queue |
| rf_rx_wr | input | 1 | Radio push strobe into the receive queue |
| rf_rx_data | input | 8 | Byte pushed by the radio |
| rf_tx_rd | input | 1 | Radio pop strobe from the transmit queue |
| rf_tx_data | output | 8 | Oldest byte of the transmit queue |
| host_rx_rd | input | 1 | Host pop strobe from the receive queue |
| host_rx_data | output | 8 | Oldest byte of the receive queue |
| host_tx_wr | input | 1 | Host push strobe into the transmit queue |
| host_tx_data | input | 8 | Byte pushed by the host |
| host_acc | input | 1 | A host access is in progress |
| host_acc_rd | input | 1 | Host access direction, 1 = read, 0 = write |
| rx_count | output | 7 | Bytes stored in the receive queue |
| tx_count | output | 7 | Bytes stored in the transmit queue |
| rx_thr_flag | output | 1 | Receive count at or above its threshold |
| tx_thr_flag | output | 1 | Transmit count at or above its threshold |
| fill_ind | output | 4 | Capped fill of the queue the access selects |
| rx_overflow_err | output | 1 | Sticky: radio wrote to a full receive queue |
| rx_underread_err | output | 1 | Sticky: host read an empty receive queue |
| tx_overfill_err | output | 1 | Sticky: host wrote to a full transmit queue |
| tx_underflow_err | output | 1 | Sticky: radio read an empty transmit queue |

## Verification
The assertions check several properties on every cycle:
- a refused write at full or a refused read at empty leaves the count where it was;
- error flags stay set until a flush;
- a simultaneous read and write keeps the count steady, and with one byte stored the new byte becomes the front;
- the occupancy state agrees with the count;
- the threshold flags take their fixed values at the extreme counts;
- the capped fill indication saturates.

Only the bench scenarios can show the rest. These are:
- the byte ordering through a full 64-entry cycle;
- the exact trip point of each flag for all sixteen settings at every count;
- that a flush of one queue leaves the other queue's state alone.

// File: rtl/pfifo_pkg.sv
`timescale 1ns/1ps
package pfifo_pkg;

    // Occupancy of one queue
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

    localparam int PF_DEPTH  = 64;
    localparam int PF_DATA_W = 8;
    localparam int PF_THR_W  = 4;
    localparam int PF_FILL_W = 4;

endpackage

// File: rtl/pfifo_core.sv
`timescale 1ns/1ps
module pfifo_core
    import pfifo_pkg::*;
#(
    parameter  int DEPTH  = PF_DEPTH,
    parameter  int DATA_W = PF_DATA_W,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              wr_err,
    output logic              rd_err
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit POW2  = ((DEPTH & (DEPTH - 1)) == 0);

    occ_state_t        state_q, state_d;
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q, wr_ptr_nx, rd_ptr_nx;
    logic [CNT_W-1:0]  count_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              is_empty, is_full, wr_ok, rd_ok;
    logic              wr_err_q, rd_err_q;

    // Pointer advance: free wrap for power-of-two depth, compare otherwise
    generate
        if (POW2) begin : g_wrap_pow2
            assign wr_ptr_nx = wr_ptr_q + PTR_W'(1);
            assign rd_ptr_nx = rd_ptr_q + PTR_W'(1);
        end else begin : g_wrap_cmp
            assign wr_ptr_nx = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
            assign rd_ptr_nx = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
        end
    endgenerate

    // Output decode of the occupancy state
    always_comb begin
        is_empty = 1'b0;
        is_full  = 1'b0;
        unique case (state_q)
            OCC_EMPTY:   is_empty = 1'b1;
            OCC_PARTIAL: ;
            OCC_FULL:    is_full  = 1'b1;
            default:     is_empty = 1'b1;
        endcase
    end

    assign wr_ok = wr_en & ~is_full  & ~flush;
    assign rd_ok = rd_en & ~is_empty & ~flush;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = OCC_EMPTY;
        end else begin
            unique case (state_q)
                OCC_EMPTY: begin
                    if (wr_ok) state_d = OCC_PARTIAL;
                end
                OCC_PARTIAL: begin
                    if (wr_ok && !rd_ok && count_q == CNT_W'(DEPTH - 1))
                        state_d = OCC_FULL;
                    else if (rd_ok && !wr_ok && count_q == CNT_W'(1))
                        state_d = OCC_EMPTY;
                end
                OCC_FULL: begin
                    if (rd_ok) state_d = OCC_PARTIAL;
                end
                default: state_d = OCC_EMPTY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // Pointers, count and sticky errors
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            wr_err_q <= 1'b0;
            rd_err_q <= 1'b0;
        end else begin
            if (wr_ok) wr_ptr_q <= wr_ptr_nx;
            if (rd_ok) rd_ptr_q <= rd_ptr_nx;
            unique case ({wr_ok, rd_ok})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
            if (wr_en && is_full)  wr_err_q <= 1'b1;
            if (rd_en && is_empty) rd_err_q <= 1'b1;
        end
    end

    // Storage
    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[wr_ptr_q] <= wr_data;
    end

    assign rd_data = mem_q[rd_ptr_q];
    assign count   = count_q;
    assign wr_err  = wr_err_q;
    assign rd_err  = rd_err_q;

    // Refused write at full keeps the count
    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && wr_en && !rd_en && !flush) |=> (count_q == CNT_W'(DEPTH)));

    // Refused read at empty keeps the count
    assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && rd_en && !wr_en && !flush) |=> (count_q == '0));

    // Error flags are sticky until flush
    assert_wr_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err_q && !flush) |=> wr_err_q);
    assert_rd_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_err_q && !flush) |=> rd_err_q);

    // Simultaneous accepted read and write leaves the count
    assert_rdwr_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && rd_ok) |=> $stable(count_q));

    // Single stored byte plus read+write: the new byte becomes the front
    assert_one_byte_front_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_W'(1) && wr_ok && rd_ok) |=> (rd_ptr_q == $past(wr_ptr_q)));

    // Occupancy state agrees with the count
    assert_state_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty == (count_q == '0)) && (is_full == (count_q == CNT_W'(DEPTH))));

    // Flush empties the queue
    assert_flush_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0 && !wr_err_q && !rd_err_q));

endmodule

// File: rtl/pfifo_thresh.sv
`timescale 1ns/1ps
module pfifo_thresh
    import pfifo_pkg::*;
#(
    parameter  int DEPTH = PF_DEPTH,
    parameter  int THR_W = PF_THR_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thr_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    output logic             rx_flag,
    output logic             tx_flag
);

    localparam int STEP = DEPTH >> THR_W;
    localparam int CW1  = CNT_W + 1;

    logic [CW1-1:0] rx_level, tx_level;

    // Mirrored levels: rx = STEP*(N+1), tx = DEPTH+1 - STEP*(N+1)
    always_comb begin
        rx_level = CW1'(STEP) * (CW1'(thr_sel) + CW1'(1));
        tx_level = CW1'(DEPTH + 1) - rx_level;
    end

    assign rx_flag = ({1'b0, rx_count} >= rx_level);
    assign tx_flag = ({1'b0, tx_count} >= tx_level);

    // Extreme counts give fixed flag values for any setting
    assert_rx_flag_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CNT_W'(DEPTH)) |-> rx_flag);
    assert_rx_flag_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count < CNT_W'(STEP)) |-> !rx_flag);
    assert_tx_flag_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |-> !tx_flag);
    assert_tx_flag_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count >= CNT_W'(DEPTH + 1 - STEP)) |-> tx_flag);

endmodule

// File: rtl/pfifo_fill_sel.sv
`timescale 1ns/1ps
module pfifo_fill_sel
    import pfifo_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int FILL_W = PF_FILL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              acc_rd,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    output logic [FILL_W-1:0] fill
);

    localparam int FILL_MAX = (1 << FILL_W) - 1;

    logic [CNT_W-1:0] pick;

    always_comb begin
        pick = acc_rd ? rx_count : tx_count;
        if (!acc)
            fill = '0;
        else if (pick > CNT_W'(FILL_MAX))
            fill = FILL_W'(FILL_MAX);
        else
            fill = pick[FILL_W-1:0];
    end

    assert_fill_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> (fill == '0));
    assert_fill_sat_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && acc_rd && rx_count >= CNT_W'(FILL_MAX)) |-> (fill == FILL_W'(FILL_MAX)));
    assert_fill_sat_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !acc_rd && tx_count >= CNT_W'(FILL_MAX)) |-> (fill == FILL_W'(FILL_MAX)));

endmodule

// File: rtl/paired_fifo_ctrl.sv
`timescale 1ns/1ps
module paired_fifo_ctrl
    import pfifo_pkg::*;
#(
    parameter  int DEPTH  = PF_DEPTH,
    parameter  int DATA_W = PF_DATA_W,
    parameter  int THR_W  = PF_THR_W,
    parameter  int FILL_W = PF_FILL_W,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [THR_W-1:0]  thr_sel,
    input  logic              rx_flush,
    input  logic              tx_flush,
    input  logic              rf_rx_wr,
    input  logic [DATA_W-1:0] rf_rx_data,
    input  logic              rf_tx_rd,
    output logic [DATA_W-1:0] rf_tx_data,
    input  logic              host_rx_rd,
    output logic [DATA_W-1:0] host_rx_data,
    input  logic              host_tx_wr,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic              host_acc,
    input  logic              host_acc_rd,
    output logic [CNT_W-1:0]  rx_count,
    output logic [CNT_W-1:0]  tx_count,
    output logic              rx_thr_flag,
    output logic              tx_thr_flag,
    output logic [FILL_W-1:0] fill_ind,
    output logic              rx_overflow_err,
    output logic              rx_underread_err,
    output logic              tx_overfill_err,
    output logic              tx_underflow_err
);

    // Receive queue: radio writes, host reads
    pfifo_core #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_flush),
        .wr_en   (rf_rx_wr),
        .wr_data (rf_rx_data),
        .rd_en   (host_rx_rd),
        .rd_data (host_rx_data),
        .count   (rx_count),
        .wr_err  (rx_overflow_err),
        .rd_err  (rx_underread_err)
    );

    // Transmit queue: host writes, radio reads
    pfifo_core #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tx_flush),
        .wr_en   (host_tx_wr),
        .wr_data (host_tx_data),
        .rd_en   (rf_tx_rd),
        .rd_data (rf_tx_data),
        .count   (tx_count),
        .wr_err  (tx_overfill_err),
        .rd_err  (tx_underflow_err)
    );

    pfifo_thresh #(.DEPTH(DEPTH), .THR_W(THR_W)) u_thresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_sel  (thr_sel),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_flag  (rx_thr_flag),
        .tx_flag  (tx_thr_flag)
    );

    pfifo_fill_sel #(.CNT_W(CNT_W), .FILL_W(FILL_W)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (host_acc),
        .acc_rd   (host_acc_rd),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .fill     (fill_ind)
    );

endmodule

// File: tb/tb_paired_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_paired_fifo_ctrl;

    logic       clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic       rst_n;
    logic [3:0] thr_sel;
    logic       rx_flush, tx_flush;
    logic       rf_rx_wr, rf_tx_rd, host_rx_rd, host_tx_wr;
    logic [7:0] rf_rx_data, rf_tx_data, host_rx_data, host_tx_data;
    logic       host_acc, host_acc_rd;
    logic [6:0] rx_count, tx_count;
    logic       rx_thr_flag, tx_thr_flag;
    logic [3:0] fill_ind;
    logic       rx_overflow_err, rx_underread_err, tx_overfill_err, tx_underflow_err;

    paired_fifo_ctrl dut (.*);

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] mdl_rx[$], mdl_tx[$];   // queue contents model
    logic [7:0] sb_rx[$],  sb_tx[$];    // scoreboard: expected read bytes
    logic       chk_rx = 1'b0, chk_tx = 1'b0;
    logic       e_rx_ovf = 1'b0, e_rx_udr = 1'b0, e_tx_ovf = 1'b0, e_tx_udf = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compares read data against the scoreboard
    always begin
        @(negedge clk);
        #2;
        if (chk_rx) begin
            logic [7:0] e;
            e = sb_rx.pop_front();
            chk(host_rx_data == e, "R2 receive read order", int'(host_rx_data), int'(e));
        end
        if (chk_tx) begin
            logic [7:0] e;
            e = sb_tx.pop_front();
            chk(rf_tx_data == e, "R2 transmit read order", int'(rf_tx_data), int'(e));
        end
    end

    // Driver: one cycle of strobes; model decides acceptance from pre-state
    task automatic step(input logic rxw, input logic [7:0] rxb, input logic rxr,
                        input logic txw, input logic [7:0] txb, input logic txr);
        bit rw_ok, rr_ok, tw_ok, tr_ok;
        @(negedge clk);
        rf_rx_wr = rxw; rf_rx_data = rxb; host_rx_rd = rxr;
        host_tx_wr = txw; host_tx_data = txb; rf_tx_rd = txr;
        rw_ok = rxw && (mdl_rx.size() < 64);
        rr_ok = rxr && (mdl_rx.size() > 0);
        tw_ok = txw && (mdl_tx.size() < 64);
        tr_ok = txr && (mdl_tx.size() > 0);
        if (rxw && !rw_ok) e_rx_ovf = 1'b1;
        if (rxr && !rr_ok) e_rx_udr = 1'b1;
        if (txw && !tw_ok) e_tx_ovf = 1'b1;
        if (txr && !tr_ok) e_tx_udf = 1'b1;
        chk_rx = rr_ok;
        chk_tx = tr_ok;
        if (rr_ok) begin sb_rx.push_back(mdl_rx[0]); void'(mdl_rx.pop_front()); end
        if (tr_ok) begin sb_tx.push_back(mdl_tx[0]); void'(mdl_tx.pop_front()); end
        if (rw_ok) mdl_rx.push_back(rxb);
        if (tw_ok) mdl_tx.push_back(txb);
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic do_flush(input logic frx, input logic ftx);
        @(negedge clk);
        rx_flush = frx; tx_flush = ftx;
        rf_rx_wr = 1'b1; host_tx_wr = 1'b1;   // strobes in flush cycle are ignored
        rf_rx_data = 8'hC3; host_tx_data = 8'h3C;
        chk_rx = 1'b0; chk_tx = 1'b0;
        if (frx) begin mdl_rx.delete(); e_rx_ovf = 1'b0; e_rx_udr = 1'b0; end
        else if (mdl_rx.size() < 64) mdl_rx.push_back(8'hC3);
        else e_rx_ovf = 1'b1;
        if (ftx) begin mdl_tx.delete(); e_tx_ovf = 1'b0; e_tx_udf = 1'b0; end
        else if (mdl_tx.size() < 64) mdl_tx.push_back(8'h3C);
        else e_tx_ovf = 1'b1;
        @(negedge clk);
        rx_flush = 1'b0; tx_flush = 1'b0;
        rf_rx_wr = 1'b0; host_tx_wr = 1'b0;
    endtask

    function automatic int min15(input int v);
        return (v > 15) ? 15 : v;
    endfunction

    // Checks state against the model; called at a negedge after idle()
    task automatic check_all(input string tag);
        #3;
        chk(rx_count == 7'(mdl_rx.size()), {"R9 rx_count ", tag}, int'(rx_count), mdl_rx.size());
        chk(tx_count == 7'(mdl_tx.size()), {"R9 tx_count ", tag}, int'(tx_count), mdl_tx.size());
        chk(rx_overflow_err == e_rx_ovf, {"R3 rx_overflow_err ", tag}, int'(rx_overflow_err), int'(e_rx_ovf));
        chk(tx_overfill_err == e_tx_ovf, {"R3 tx_overfill_err ", tag}, int'(tx_overfill_err), int'(e_tx_ovf));
        chk(rx_underread_err == e_rx_udr, {"R4 rx_underread_err ", tag}, int'(rx_underread_err), int'(e_rx_udr));
        chk(tx_underflow_err == e_tx_udf, {"R4 tx_underflow_err ", tag}, int'(tx_underflow_err), int'(e_tx_udf));
        chk(rx_thr_flag == (mdl_rx.size() >= 4 * (int'(thr_sel) + 1)), {"R6 rx flag ", tag},
            int'(rx_thr_flag), int'(mdl_rx.size() >= 4 * (int'(thr_sel) + 1)));
        chk(tx_thr_flag == (mdl_tx.size() >= 61 - 4 * int'(thr_sel)), {"R7 tx flag ", tag},
            int'(tx_thr_flag), int'(mdl_tx.size() >= 61 - 4 * int'(thr_sel)));
        host_acc = 1'b1; host_acc_rd = 1'b1; #0.5;
        chk(fill_ind == 4'(min15(mdl_rx.size())), {"R8 fill read ", tag}, int'(fill_ind), min15(mdl_rx.size()));
        host_acc_rd = 1'b0; #0.5;
        chk(fill_ind == 4'(min15(mdl_tx.size())), {"R8 fill write ", tag}, int'(fill_ind), min15(mdl_tx.size()));
        host_acc = 1'b0; #0.5;
        chk(fill_ind == 4'd0, {"R8 fill idle ", tag}, int'(fill_ind), 0);
    endtask

    // Sweeps all sixteen settings at the present counts
    task automatic sweep_thr();
        logic [3:0] keep;
        keep = thr_sel;
        for (int t = 0; t < 16; t++) begin
            thr_sel = 4'(t);
            #0.2;
            chk(rx_thr_flag == (mdl_rx.size() >= 4 * (t + 1)), "R6 rx threshold sweep",
                int'(rx_thr_flag), int'(mdl_rx.size() >= 4 * (t + 1)));
            chk(tx_thr_flag == (mdl_tx.size() >= 61 - 4 * t), "R7 tx threshold sweep",
                int'(tx_thr_flag), int'(mdl_tx.size() >= 61 - 4 * t));
        end
        thr_sel = keep;
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; thr_sel = 4'd13; rx_flush = 1'b0; tx_flush = 1'b0;
        rf_rx_wr = 1'b0; rf_tx_rd = 1'b0; host_rx_rd = 1'b0; host_tx_wr = 1'b0;
        rf_rx_data = '0; host_tx_data = '0; host_acc = 1'b0; host_acc_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 after reset");

        // R2 / R9: short bursts on both queues
        for (int i = 0; i < 5; i++) step(1'b1, 8'(8'h10 + i), 1'b0, 1'b1, 8'(8'hA0 + i), 1'b0);
        idle(); check_all("R9 after five writes");
        for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1);
        idle(); check_all("R2 after drain");

        // R5: one stored byte with simultaneous read and write
        step(1'b1, 8'h55, 1'b0, 1'b1, 8'h5A, 1'b0); idle();
        step(1'b1, 8'h66, 1'b1, 1'b1, 8'h6A, 1'b1); idle();
        check_all("R5 one byte rd+wr");
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1); idle();
        check_all("R5 no duplicate");

        // R6: fill the receive queue, sweeping thresholds at each count
        for (int n = 0; n < 64; n++) begin
            step(1'b1, 8'(n * 7 + 3), 1'b0, 1'b0, 8'h00, 1'b0); idle();
            check_all("R6 rx fill");
            sweep_thr();
        end
        step(1'b1, 8'hEE, 1'b0, 1'b0, 8'h00, 1'b0); idle();
        check_all("R3 rx write at full");
        step(1'b1, 8'h77, 1'b1, 1'b0, 8'h00, 1'b0); idle();
        check_all("R5 rd+wr at full");
        step(1'b1, 8'h78, 1'b0, 1'b0, 8'h00, 1'b0); idle();
        for (int n = 0; n < 64; n++) step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        idle(); check_all("R2 rx drained");
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0); idle();
        check_all("R4 rx read at empty");
        step(1'b1, 8'h99, 1'b1, 1'b0, 8'h00, 1'b0); idle();
        check_all("R5 rd+wr at empty");

        // R7: fill the transmit queue
        for (int n = 0; n < 64; n++) begin
            step(1'b0, 8'h00, 1'b0, 1'b1, 8'(n * 5 + 1), 1'b0); idle();
            check_all("R7 tx fill");
            sweep_thr();
        end
        step(1'b0, 8'h00, 1'b0, 1'b1, 8'hDD, 1'b0); idle();
        check_all("R3 tx write at full");

        // R1: flush receive only; transmit keeps state and errors
        do_flush(1'b1, 1'b0); idle();
        check_all("R1 rx flush");
        for (int n = 0; n < 63; n++) step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
        idle(); check_all("R2 tx partial drain");
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1); idle();
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1); idle();
        check_all("R4 tx read at empty");

        // R1: flush transmit; receive unaffected
        step(1'b1, 8'h42, 1'b0, 1'b1, 8'h24, 1'b0); idle();
        do_flush(1'b0, 1'b1); idle();
        check_all("R1 tx flush");
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0); idle();
        check_all("R2 after flush");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule